// File: doc/BRIEF.md
# Zigzag Rounding Coefficient Quantizer

This block takes 8x8 blocks of transform coefficients and turns each one into a block of quantized values. The coefficients arrive in natural row-major order. For every output slot the block fetches the coefficient that the zigzag scan assigns to that slot. It divides that coefficient by a step size and rounds half away from zero. The result leaves in zigzag order.

Blocks follow a fixed macroblock rhythm: four luma blocks, then two chroma blocks, then the pattern repeats. A six-state block counter inside the block follows this rhythm and picks the step table. Both tables are constant and are computed inside the block, so nothing has to be loaded at run time.

Both sides stream with valid/ready. A block is first stored in full. It is then emitted one value at a time, and a serial restoring divider works out each quotient.

Top module: `zz_quant`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `out_valid` is 0, and the next block is treated as block-type 0 (luma).
- R2: No quantized value is offered until all 64 coefficients of the block have been accepted. While a block is being loaded, `out_valid` stays 0.
- R3: Output slot i (0..63) carries the coefficient at row-major position zz(i). zz is the zigzag walk that starts at (0,0), steps right to (0,1), and then sweeps the anti-diagonals in alternating directions. For example zz(1)=1, zz(2)=8, zz(3)=16 and zz(63)=63.
- R4: For a coefficient v > 0 with step q, the output is (v + floor(q/2)) / q.
- R5: For a coefficient v <= 0, the output is (v - floor(q/2)) / q, with the division truncating toward zero. Zero therefore maps to zero.
- R6: The block-type counter advances 0,1,2,3,4,5,0,... once per completed block. Bit 2 of the counter selects the chroma table, so types 0-3 use luma and types 4-5 use chroma.
- R7: The step for output slot i is i+1 in the luma table and 2*i+3 in the chroma table. Every entry is an unsigned 8-bit value and none is zero.
- R8: `out_last` is 1 exactly on output slot 63 of each block.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values, and no value is dropped.
- R10: Coefficients are 32-bit two's complement. The output is the low 24 bits of the exact two's-complement quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Coefficient, row-major order |
| in_valid | input | 1 | Coefficient present |
| in_ready | output | 1 | Block accepts a coefficient |
| out_data | output | 24 | Quantized value, zigzag order |
| out_valid | output | 1 | Quantized value present |
| out_ready | input | 1 | Consumer accepts the value |
| out_last | output | 1 | Marks slot 63 of a block |

## Verification
The bench builds the block with its default parameters: 32-bit coefficients, 24-bit results, 8-bit steps and an 8x8 block. With these settings the full 33-bit magnitude path is reachable. One luma block contains +2147483647 at a step of 1 and -2147483648 at a step of 2, which exercises the 24-bit truncation of R10. Seven blocks are sent so that the type counter covers both chroma slots and wraps back to luma. The consumer throttles `out_ready` on a fixed pattern, so stalls land on many slot positions, including the last one.

// File: rtl/zz_quant.sv
module zz_quant #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 24,
  parameter int Q_W   = 8,
  parameter int DIM   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last
);
  localparam int NCOEF  = DIM * DIM;
  localparam int IW     = $clog2(NCOEF);
  localparam int MW     = IN_W + 1;
  localparam int SW     = $clog2(MW + 1);
  localparam int NTYPES = 6;

  typedef enum logic [1:0] {S_LOAD, S_INIT, S_DIV, S_OUT} state_t;

  function automatic int zz_pos(input int i);
    int base, len, k, r, c;
    base = 0; r = 0; c = 0;
    for (int d = 0; d <= 2*DIM-2; d++) begin
      len = (d < DIM) ? d + 1 : 2*DIM - 1 - d;
      if (i >= base && i < base + len) begin
        k = i - base;
        if (d % 2 == 0) begin
          r = ((d < DIM) ? d : DIM - 1) - k;
          c = d - r;
        end else begin
          c = ((d < DIM) ? d : DIM - 1) - k;
          r = d - c;
        end
      end
      base += len;
    end
    return r * DIM + c;
  endfunction

  function automatic logic [Q_W-1:0] qval(input logic chroma, input logic [IW-1:0] i);
    return chroma ? Q_W'(2 * int'(i) + 3) : Q_W'(int'(i) + 1);
  endfunction

  state_t            state;
  logic [IW-1:0]     idx;
  logic [SW-1:0]     step;
  logic [2:0]        btype;
  logic [Q_W:0]      rem;
  logic [MW-1:0]     quo;
  logic              neg;
  logic [IN_W-1:0]   coef_mem [NCOEF];
  logic [IW-1:0]     zz_map [NCOEF];

  for (genvar gi = 0; gi < NCOEF; gi++) begin : g_zz
    assign zz_map[gi] = IW'(zz_pos(gi));
  end

  logic [IN_W-1:0] cur;
  logic [MW-1:0]   cur_x, mag, mag_r;
  logic [Q_W-1:0]  qcur;
  logic [Q_W:0]    r2;
  logic            ge;

  assign cur   = coef_mem[zz_map[idx]];
  assign cur_x = {cur[IN_W-1], cur};
  assign qcur  = qval(btype[2], idx);
  assign mag   = cur_x[MW-1] ? (~cur_x + MW'(1)) : cur_x;
  assign mag_r = mag + MW'(qcur >> 1);
  assign r2    = {rem[Q_W-1:0], quo[MW-1]};
  assign ge    = r2 >= {1'b0, qcur};

  assign in_ready  = (state == S_LOAD);
  assign out_valid = (state == S_OUT);
  assign out_last  = out_valid && (idx == IW'(NCOEF - 1));
  assign out_data  = neg ? (~quo[OUT_W-1:0] + OUT_W'(1)) : quo[OUT_W-1:0];

  always_ff @(posedge clk)
    if (state == S_LOAD && in_valid) coef_mem[idx] <= in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_LOAD;
      idx   <= '0;
      step  <= '0;
      btype <= '0;
      rem   <= '0;
      quo   <= '0;
      neg   <= 1'b0;
    end else begin
      case (state)
        S_LOAD: if (in_valid) begin
          idx <= idx + IW'(1);
          if (idx == IW'(NCOEF - 1)) state <= S_INIT;
        end
        S_INIT: begin
          quo   <= mag_r;
          rem   <= '0;
          neg   <= cur_x[MW-1];
          step  <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          rem  <= ge ? (r2 - {1'b0, qcur}) : r2;
          quo  <= {quo[MW-2:0], ge};
          step <= step + SW'(1);
          if (step == SW'(MW - 1)) state <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          idx <= idx + IW'(1);
          if (idx == IW'(NCOEF - 1)) begin
            btype <= (btype == 3'(NTYPES - 1)) ? 3'd0 : btype + 3'd1;
            state <= S_LOAD;
          end else begin
            state <= S_INIT;
          end
        end
        default: state <= S_LOAD;
      endcase
    end
  end

  a_r2_quiet_during_load: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && idx != IW'(NCOEF - 1)) |=> !out_valid);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r8_last_ends_block: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  a_r6_type_sequence: assert property (@(posedge clk) disable iff (rst)
    !$stable(btype) |-> (btype == (($past(btype) == 3'(NTYPES - 1)) ? 3'd0 : $past(btype) + 3'd1)));

  a_r6_type_range: assert property (@(posedge clk) disable iff (rst)
    btype < 3'(NTYPES));

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (in_ready && !out_valid && btype == 3'd0));
endmodule

// File: tb/tb_zz_quant.sv
module tb_zz_quant;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] in_data = '0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [23:0] out_data;
  logic        out_valid;
  logic        out_ready = 0;
  logic        out_last;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  logic [24:0] exp_q [$];
  string       tag_q [$];
  int          zz [64];

  always #2.5 clk = ~clk;

  zz_quant dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint pat(input int b, input int p);
    case (b % 5)
      0: return longint'((p * 37) % 201) - 100;
      1: return -longint'(p * 13 + 1);
      2: return longint'(p % 7) - 3;
      3: begin
        if (p == 0) return 64'sd2147483647;
        if (p == 1) return -64'sd2147483648;
        return (p % 2) ? -longint'(p * 123457) : longint'(p * 123457);
      end
      default: return longint'(p) * 1000 - 30000;
    endcase
  endfunction

  task automatic send_block(input int b);
    longint v [64];
    int     bt;
    bt = b % 6;
    for (int p = 0; p < 64; p++) v[p] = pat(b, p);
    for (int i = 0; i < 64; i++) begin
      longint q, h, c, res;
      c = v[zz[i]];
      q = (bt >= 4) ? longint'(2 * i + 3) : longint'(i + 1);
      h = q / 2;
      res = (c > 0) ? (c + h) / q : (c - h) / q;
      exp_q.push_back({(i == 63), res[23:0]});
      tag_q.push_back($sformatf("R3 R7 %s %s R10 blk%0d slot%0d",
                                (c > 0) ? "R4" : "R5", (bt >= 4) ? "R6chroma" : "R6luma", b, i));
    end
    for (int p = 0; p < 64; p++) begin
      @(negedge clk);
      if (p % 9 == 4) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_data  = 32'(v[p]);
      in_valid = 1;
      while (!in_ready) @(negedge clk);
      if (p == 63) check(out_valid == 0, "R2 output before full block", out_valid, 0);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    int r, c;
    bit up;
    r = 0; c = 0; up = 1;
    for (int i = 0; i < 64; i++) begin
      zz[i] = r * 8 + c;
      if (up) begin
        if (c == 7) begin r++; up = 0; end
        else if (r == 0) begin c++; up = 0; end
        else begin r--; c++; end
      end else begin
        if (r == 7) begin c++; up = 1; end
        else if (c == 0) begin r++; up = 1; end
        else begin r++; c--; end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    out_ready = !((cyc % 7 == 3) || (cyc % 11 == 5));
  end

  logic        prev_stall = 0;
  logic [23:0] prev_data;
  logic        prev_last;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        check(out_valid && out_data == prev_data && out_last == prev_last,
              "R9 hold under stall", longint'(out_data), longint'(prev_data));
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected output", longint'(out_data), 0);
        end else begin
          logic [24:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e[23:0], t, longint'($signed(out_data)), longint'($signed(e[23:0])));
          check(out_last == e[24], "R8 last flag", longint'(out_last), longint'(e[24]));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    for (int b = 0; b < 7; b++) send_block(b);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(in_ready == 1 && out_valid == 0, "R8 idle after last slot", in_ready, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule